// File: doc/BRIEF.md
# Dual-Domain Pixel Output Driver

This block takes pixels made by a video generator clocked at 100 MHz and turns them into a raster on a VGA or HDMI style pixel interface. All output timing runs on one 120 MHz clock. A clock enable sets the pixel rate: one pixel every three ticks gives 40 MHz for the 60 Hz mode, and one pixel every four ticks gives 30 MHz for the 50 Hz mode. The block has no separate pixel clocks.

Pixel data crosses between the two clock domains through a small dual-clock FIFO with Gray-coded pointers. Nothing else crosses. The generator side gets its own start-of-frame, start-of-raster and pixel-request strobes, made locally at 100 MHz from a count of accepted pixels. These strobes need not line up in time with the output raster, because the FIFO absorbs the difference. The producer sees a ready/valid push port: `pix_req_o` is the ready, and a pixel is accepted on a 100 MHz edge where both `pix_req_o` and `pix_valid_i` are high.

On the output side, a horizontal and vertical counter advances on each pixel-enable tick. RGB, data enable and both syncs are registered together on that tick, and `pix_stb_o` pulses for one cycle after each update. After reset the output raster starts at the first vertical blanking line, so the FIFO can fill before the first visible pixel.

Top module: `pix_out_driver`

## Requirements
- R1: While reset is held, `rgb_o`, `hsync_o`, `vsync_o`, `de_o`, `pix_stb_o` and `underflow_o` are 0, and `pix_req_o` is 1 (the FIFO is empty).
- R2: With `mode_i` = 0 (40 MHz rate), the outputs update every 3 cycles of `clk_out_i`, and `pix_stb_o` pulses exactly 3 cycles apart.
- R3: With `mode_i` = 1 (30 MHz rate), the outputs update every 4 cycles of `clk_out_i`, and `pix_stb_o` pulses exactly 4 cycles apart.
- R4: `de_o` is 1 exactly on active positions (h < H_ACT and v < V_ACT). Active positions show the accepted pixels in the order they were pushed, one per position, scanning left to right and then top to bottom.
- R5: A line lasts H_ACT+H_FP+H_SYNC+H_BP pixel ticks, with `hsync_o` high (active high) for H_SYNC ticks starting at h = H_ACT+H_FP. A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines, with `vsync_o` high for lines V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1.
- R6: `rgb_o` is 0 (black) at every non-active position.
- R7: If the FIFO is empty at an active pixel tick, that pixel is shown black and `underflow_o` goes to 1. `underflow_o` then stays at 1 until reset, and stays at 0 in runs where the FIFO never runs dry.
- R8: When `pix_req_o` is high, `sol_o` is high exactly when the next accepted pixel is the first of an active line, and `sof_o` is high exactly when it is the first pixel of a frame. The generator side counts H_ACT pixels per line and V_ACT lines per frame.
- R9: `pix_req_o` is 0 while the FIFO is full. A `pix_valid_i` pulse while `pix_req_o` is 0 is ignored and never reaches the output.
- R10: The read and write pointers that cross domains change by at most one bit per cycle of their own clock (Gray code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_gen_i | input | 1 | 100 MHz generator clock |
| clk_out_i | input | 1 | 120 MHz output clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| pix_data_i | input | PIX_W | Pixel to push, RGB packed (generator domain) |
| pix_valid_i | input | 1 | Push request (generator domain) |
| pix_req_o | output | 1 | FIFO can accept a pixel (generator domain) |
| sof_o | output | 1 | Next accepted pixel starts a frame |
| sol_o | output | 1 | Next accepted pixel starts a line |
| mode_i | input | 1 | 0: one pixel per 3 ticks, 1: one pixel per 4 ticks (output domain) |
| rgb_o | output | PIX_W | Pixel colour, black in blanking |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Active video |
| pix_stb_o | output | 1 | One-cycle pulse after each output update |
| underflow_o | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench runs the two clocks at unrelated phases and compares every active output pixel with the order of pushes in both rate modes. A design that counted ticks wrong, or lost a pixel or shifted one across the crossing, would fail those compares. The producer keeps `pix_valid_i` high while the FIFO is full and drives a marker value in those cycles, so a design that accepted pushes while full would leak the marker into the raster. A run with the producer stalled checks that starved active pixels come out black and that the underflow flag stays set after data flows again. Each output update is also checked against a model of the line and frame geometry, so a misplaced sync pulse or a non-black blanking pixel is caught.

// File: rtl/pix_drv_pkg.sv
package pix_drv_pkg;
  typedef enum logic {MODE_40M = 1'b0, MODE_30M = 1'b1} pix_mode_e;

  // last phase of the 120 MHz tick divider
  function automatic logic [2:0] last_phase(input pix_mode_e m);
    return (m == MODE_30M) ? 3'd3 : 3'd2;
  endfunction

  function automatic logic [7:0] bin2gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/pix_sync2.sv
module pix_sync2 #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pix_async_fifo.sv
module pix_async_fifo #(
  parameter int W  = 24,
  parameter int AW = 4
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  import pix_drv_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_bin_q, wr_gray_q, rd_bin_q, rd_gray_q;
  logic [PW-1:0] rd_gray_w, wr_gray_r;
  logic [PW-1:0] wr_bin_nx, rd_bin_nx;
  logic [7:0]    wr_g8, rd_g8;
  logic          wr_en, rd_en;

  assign wr_bin_nx = wr_bin_q + PW'(1);
  assign rd_bin_nx = rd_bin_q + PW'(1);
  assign wr_g8     = bin2gray(8'(wr_bin_nx));
  assign rd_g8     = bin2gray(8'(rd_bin_nx));

  assign full_o  = (wr_gray_q == {~rd_gray_w[PW-1:PW-2], rd_gray_w[PW-3:0]});
  assign empty_o = (rd_gray_q == wr_gray_r);
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && !empty_o;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
    end else if (wr_en) begin
      wr_bin_q  <= wr_bin_nx;
      wr_gray_q <= wr_g8[PW-1:0];
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_en) mem_q[wr_bin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
    end else if (rd_en) begin
      rd_bin_q  <= rd_bin_nx;
      rd_gray_q <= rd_g8[PW-1:0];
    end
  end

  assign rdata_o = mem_q[rd_bin_q[AW-1:0]];

  pix_sync2 #(.W(PW)) u_rd2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_gray_q), .q_o(rd_gray_w));
  pix_sync2 #(.W(PW)) u_wr2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_gray_q), .q_o(wr_gray_r));

  p_wr_gray_step_r10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wr_gray_q ^ $past(wr_gray_q)) <= 1);
  p_rd_gray_step_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rd_gray_q ^ $past(rd_gray_q)) <= 1);
  p_no_overflow_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |=> (wr_bin_q == $past(wr_bin_q)));
  p_no_underread_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |=> (rd_bin_q == $past(rd_bin_q)));
endmodule

// File: rtl/pix_gen_strobes.sv
module pix_gen_strobes #(
  parameter int H_ACT = 16,
  parameter int V_ACT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic sol_o,
  output logic sof_o
);
  localparam int XW = (H_ACT > 2) ? $clog2(H_ACT) : 1;
  localparam int YW = (V_ACT > 2) ? $clog2(V_ACT) : 1;
  localparam logic [XW-1:0] X_LAST = XW'(H_ACT - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_ACT - 1);

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv_i) begin
      if (x_q == X_LAST) begin
        x_q <= '0;
        y_q <= (y_q == Y_LAST) ? '0 : y_q + YW'(1);
      end else begin
        x_q <= x_q + XW'(1);
      end
    end
  end

  assign sol_o = (x_q == '0);
  assign sof_o = sol_o && (y_q == '0);

  p_line_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && x_q == X_LAST) |=> (x_q == '0));
endmodule

// File: rtl/pix_out_timing.sv
module pix_out_timing #(
  parameter int PIX_W  = 24,
  parameter int H_ACT  = 16,
  parameter int H_FP   = 2,
  parameter int H_SYNC = 3,
  parameter int H_BP   = 3,
  parameter int V_ACT  = 4,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             fifo_empty_i,
  input  logic [PIX_W-1:0] fifo_data_i,
  output logic             fifo_pop_o,
  output logic [PIX_W-1:0] rgb_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             pix_stb_o,
  output logic             underflow_o
);
  import pix_drv_pkg::*;

  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam logic [HW-1:0] H_ACT_C  = HW'(H_ACT);
  localparam logic [HW-1:0] HS_BEG_C = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END_C = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [HW-1:0] H_LAST_C = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_ACT_C  = VW'(V_ACT);
  localparam logic [VW-1:0] VS_BEG_C = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END_C = VW'(V_ACT + V_FP + V_SYNC);
  localparam logic [VW-1:0] V_LAST_C = VW'(V_TOT - 1);

  logic [2:0]    div_q, div_last;
  logic          pix_en;
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          in_act, hs_c, vs_c;

  assign div_last = last_phase(pix_mode_e'(mode_i));
  assign pix_en   = (div_q == div_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (div_q >= div_last) div_q <= '0;
    else                       div_q <= div_q + 3'd1;
  end

  // raster starts in vertical blanking so the FIFO can fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= V_ACT_C;
    end else if (pix_en) begin
      if (h_q == H_LAST_C) begin
        h_q <= '0;
        v_q <= (v_q == V_LAST_C) ? '0 : v_q + VW'(1);
      end else begin
        h_q <= h_q + HW'(1);
      end
    end
  end

  assign in_act     = (h_q < H_ACT_C) && (v_q < V_ACT_C);
  assign hs_c       = (h_q >= HS_BEG_C) && (h_q < HS_END_C);
  assign vs_c       = (v_q >= VS_BEG_C) && (v_q < VS_END_C);
  assign fifo_pop_o = pix_en && in_act && !fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o       <= '0;
      hsync_o     <= 1'b0;
      vsync_o     <= 1'b0;
      de_o        <= 1'b0;
      pix_stb_o   <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      pix_stb_o <= pix_en;
      if (pix_en) begin
        rgb_o       <= (in_act && !fifo_empty_i) ? fifo_data_i : '0;
        hsync_o     <= hs_c;
        vsync_o     <= vs_c;
        de_o        <= in_act;
        underflow_o <= underflow_o | (in_act && fifo_empty_i);
      end
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en |=> !pix_en ##1 !pix_en);
  p_hold_between_ticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en |=> ($stable(rgb_o) && $stable(hsync_o) && $stable(vsync_o) && $stable(de_o)));
  p_underflow_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
endmodule

// File: rtl/pix_out_driver.sv
module pix_out_driver #(
  parameter int PIX_W  = 24,
  parameter int FIFO_AW = 4,
  parameter int H_ACT  = 16,
  parameter int H_FP   = 2,
  parameter int H_SYNC = 3,
  parameter int H_BP   = 3,
  parameter int V_ACT  = 4,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 1
) (
  input  logic             clk_gen_i,
  input  logic             clk_out_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_valid_i,
  output logic             pix_req_o,
  output logic             sof_o,
  output logic             sol_o,
  input  logic             mode_i,
  output logic [PIX_W-1:0] rgb_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             pix_stb_o,
  output logic             underflow_o
);
  logic             full, empty, pop;
  logic [PIX_W-1:0] rdata;
  logic             sol_raw, sof_raw;

  assign pix_req_o = !full;
  assign sol_o     = pix_req_o && sol_raw;
  assign sof_o     = pix_req_o && sof_raw;

  pix_async_fifo #(.W(PIX_W), .AW(FIFO_AW)) u_fifo (
    .wclk_i (clk_gen_i),
    .rclk_i (clk_out_i),
    .rst_ni (rst_ni),
    .push_i (pix_valid_i),
    .wdata_i(pix_data_i),
    .full_o (full),
    .pop_i  (pop),
    .rdata_o(rdata),
    .empty_o(empty)
  );

  pix_gen_strobes #(.H_ACT(H_ACT), .V_ACT(V_ACT)) u_strobes (
    .clk_i (clk_gen_i),
    .rst_ni(rst_ni),
    .adv_i (pix_valid_i && pix_req_o),
    .sol_o (sol_raw),
    .sof_o (sof_raw)
  );

  pix_out_timing #(
    .PIX_W(PIX_W), .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i       (clk_out_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .fifo_empty_i(empty),
    .fifo_data_i (rdata),
    .fifo_pop_o  (pop),
    .rgb_o       (rgb_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .de_o        (de_o),
    .pix_stb_o   (pix_stb_o),
    .underflow_o (underflow_o)
  );
endmodule

// File: tb/pix_out_driver_tb.sv
module pix_out_driver_tb;
  localparam int PIX_W = 24;
  localparam int H_ACT = 16, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_ACT = 4, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int ACT   = H_ACT * V_ACT;
  // {mode, expected gap}
  localparam logic [3:0] RUN_TAB [3] = '{4'b0011, 4'b1100, 4'b0011};

  logic             clk_gen_i = 1'b0, clk_out_i = 1'b0, rst_ni = 1'b0;
  logic [PIX_W-1:0] pix_data_i = '0;
  logic             pix_valid_i = 1'b0, mode_i = 1'b0;
  logic             pix_req_o, sof_o, sol_o, hsync_o, vsync_o, de_o, pix_stb_o, underflow_o;
  logic [PIX_W-1:0] rgb_o;

  int  n_chk = 0, n_fail = 0;
  int  idx = 0, rd_idx = 0, mh = 0, mv = V_ACT, exp_gap = 3;
  longint cyc = 0, last_cyc = 0;
  bit  prod_on = 0, mon_on = 0, starve = 0, have_last = 0, saw_full = 0, done = 0;

  pix_out_driver #(
    .PIX_W(PIX_W), .FIFO_AW(4), .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_dut (
    .clk_gen_i(clk_gen_i), .clk_out_i(clk_out_i), .rst_ni(rst_ni),
    .pix_data_i(pix_data_i), .pix_valid_i(pix_valid_i), .pix_req_o(pix_req_o),
    .sof_o(sof_o), .sol_o(sol_o), .mode_i(mode_i), .rgb_o(rgb_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_stb_o(pix_stb_o),
    .underflow_o(underflow_o)
  );

  always #4 clk_out_i = ~clk_out_i;
  initial begin
    #3;
    forever #5 clk_gen_i = ~clk_gen_i;
  end
  always @(posedge clk_out_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // producer: drive at negedge, push happens at next posedge when ready
  always @(negedge clk_gen_i) begin
    if (prod_on && rst_ni) begin
      pix_valid_i = 1'b1;
      if (pix_req_o) begin
        chk(sol_o == ((idx % H_ACT) == 0), "R8 sol_o", sol_o, (idx % H_ACT) == 0);
        chk(sof_o == ((idx % ACT) == 0), "R8 sof_o", sof_o, (idx % ACT) == 0);
        pix_data_i = PIX_W'(idx + 1);
        idx++;
      end else begin
        saw_full   = 1;
        pix_data_i = '1;  // marker must never be shown
      end
    end else begin
      pix_valid_i = 1'b0;
    end
  end

  // output monitor
  always @(negedge clk_out_i) begin
    if (mon_on && pix_stb_o) begin
      bit e_de, e_hs, e_vs;
      e_de = (mh < H_ACT) && (mv < V_ACT);
      e_hs = (mh >= H_ACT + H_FP) && (mh < H_ACT + H_FP + H_SYNC);
      e_vs = (mv >= V_ACT + V_FP) && (mv < V_ACT + V_FP + V_SYNC);
      if (have_last)
        chk((cyc - last_cyc) == exp_gap, (exp_gap == 3) ? "R2 tick gap" : "R3 tick gap",
            cyc - last_cyc, exp_gap);
      chk(de_o == e_de, "R4 de_o", de_o, e_de);
      chk(hsync_o == e_hs, "R5 hsync_o", hsync_o, e_hs);
      chk(vsync_o == e_vs, "R5 vsync_o", vsync_o, e_vs);
      if (!e_de) chk(rgb_o == '0, "R6 blank rgb", rgb_o, 0);
      else if (starve) chk(rgb_o == '0, "R7 starved rgb", rgb_o, 0);
      else begin
        chk(rgb_o == PIX_W'(rd_idx + 1), "R4/R9 pixel order", rgb_o, rd_idx + 1);
        rd_idx++;
      end
      last_cyc  = cyc;
      have_last = 1;
      if (mh == H_TOT - 1) begin
        mh = 0;
        mv = (mv == V_TOT - 1) ? 0 : mv + 1;
      end else mh++;
    end
  end

  task automatic do_reset();
    rst_ni  = 1'b0;
    prod_on = 0;
    mon_on  = 0;
    repeat (4) @(posedge clk_out_i);
    idx = 0; rd_idx = 0; mh = 0; mv = V_ACT; have_last = 0; saw_full = 0;
    @(negedge clk_out_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (5) @(posedge clk_out_i);
    @(negedge clk_out_i);
    chk(rgb_o == '0, "R1 rgb_o", rgb_o, 0);
    chk({hsync_o, vsync_o, de_o, pix_stb_o} == 4'b0, "R1 sync/de/stb", {hsync_o, vsync_o, de_o, pix_stb_o}, 0);
    chk(underflow_o == 1'b0, "R1 underflow_o", underflow_o, 0);
    chk(pix_req_o == 1'b1, "R1 pix_req_o", pix_req_o, 1);

    for (int r = 0; r < 3; r++) begin
      mode_i  = RUN_TAB[r][3];
      exp_gap = int'(RUN_TAB[r][2:0]);
      starve  = 0;
      do_reset();
      prod_on = 1;
      mon_on  = 1;
      repeat (3 * FRAME * exp_gap) @(posedge clk_out_i);
      @(negedge clk_out_i);
      mon_on = 0;
      chk(underflow_o == 1'b0, "R7 no underflow when fed", underflow_o, 0);
      chk(rd_idx >= 2 * ACT, "R4 pixels shown", rd_idx, 2 * ACT);
      chk(saw_full == 1, "R9 full back-pressure reached", saw_full, 1);
    end

    // starved output
    mode_i  = 1'b0;
    exp_gap = 3;
    starve  = 1;
    do_reset();
    mon_on  = 1;
    repeat (2 * FRAME * 3) @(posedge clk_out_i);
    @(negedge clk_out_i);
    mon_on = 0;
    chk(underflow_o == 1'b1, "R7 underflow raised", underflow_o, 1);
    prod_on = 1;
    repeat (400) @(posedge clk_out_i);
    @(negedge clk_out_i);
    chk(underflow_o == 1'b1, "R7 underflow sticky", underflow_o, 1);
    prod_on = 0;

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_out_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule